// File: doc/BRIEF.md
# Register-Driven I2C Master Sequencer

This block lets software run short I2C master transactions through a small byte-wide register file. A single write to the control register packs the direction, a byte count of one to four, and the stop policy between bytes. The block then walks the transfer as a series of commands to a byte-level bus engine. Each command is a start with the address byte, a data byte sent or received, or a stop. The engine answers every command with a done pulse and an acknowledge result.

The sequencer tracks whether it holds the bus, flags aborted transfers, records how many bytes moved, and raises an interrupt line on completion or on a halt. Completion and halt each have their own mask bit, and both sit behind a global enable. The bit-level SCL/SDA engine sits outside the block.

Register offsets: 0x0 control, 0x1 status, 0x2 extended status, 0x3 mode, 0x4 interrupt mask, 0x5 transfer count, 0x6 target address, 0x7 soft reset, 0x8 to 0xB data bytes 0 to 3. Reads have no side effects, and unmapped offsets read 0. Engine command codes on `eng_cmd`: 0 start, 1 write byte, 2 read byte, 3 stop.

Top module: `i2cm_seq_top`

## Requirements
- R1: After reset the registers read: control 0x00, status 0x00, extended status 0x40, mode 0x00, mask 0x00, transfer count 0x00, target address 0x00, data 0x00. `irq` and `busy` are low.
- R2: A control write with bit 0 set launches a transfer of (bits 5:4)+1 bytes, reading when bit 1 is 1. The control register stores the written value with bit 0 cleared. For each start, the engine receives the byte {target address bits 7:1, bit 1 of control}. Written bytes come from data bytes 0, 1, 2, ... in order, and read bytes land there in the same order.
- R3: A start is issued only when the bus is not held. A stop follows each byte when bit 3 (repeated start) is set or bit 2 (chain) is clear. Otherwise the bus stays held, and the next byte or the next transfer goes without a new start.
- R4: A NACK on a start or a data byte ends the transfer, sets status bit 2 and extended-status bit 0. After an address NACK the bus is free. After a data NACK the bus stays held. An acknowledged start clears status bit 2.
- R5: At the end of a transfer the transfer-count register holds the number of bytes moved. A software write to it keeps only the bits in 0x77.
- R6: When a transfer ends having moved at least one byte, with mode bit 2 and mask bit 0 both set, status bit 1 is set and `irq` goes high.
- R7: A control write with bit 7 set while the bus is held makes the block issue a stop and free the bus. If mode bit 2 and mask bit 3 are both set, it also sets status bit 1 and raises `irq`.
- R8: A status write clears only the bits of the written value within 0x0A, so status bit 2 is not software-clearable. Clearing bit 1 while mode bit 2 is set drops `irq`.
- R9: Extended status reads 0x50 while the bus is held and 0x40 when it is free, ORed with the sticky abort flag in bit 0. A write clears the set bits of the value within 0x8F.
- R10: A mode write keeps only the bits in 0x3D.
- R11: Writing 1 to bit 0 of the soft-reset register returns every register to its reset value except the target address.
- R12: `busy` and status bit 0 are high from the launch until the transfer or halt ends. While busy, writes to control, soft reset and the data bytes are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register offset |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data, combinational from `reg_addr` |
| busy | output | 1 | Transfer or halt in progress |
| irq | output | 1 | Interrupt line |
| eng_req | output | 1 | Command request to the byte engine, held until `eng_done` |
| eng_cmd | output | 2 | Command code: 0 start, 1 write, 2 read, 3 stop |
| eng_wdata | output | 8 | Address byte for start, data byte for write |
| eng_done | input | 1 | One-cycle completion pulse from the engine |
| eng_nack | input | 1 | Acknowledge missing, valid with `eng_done` |
| eng_rdata | input | 8 | Received byte, valid with `eng_done` |

## Verification
A wrong held-bus flag shows up at the engine port at the next byte. A start that should not be there appears, or a start that should be there is missing. The same fault shows in the extended-status read right after the transfer ends. A wrong byte index shows up as misordered write data on `eng_wdata` within the same transfer, and as misplaced read data as soon as the data bytes are read back. A wrong interrupt or error state is visible on `irq` and in the status read on the cycle after the transfer or halt finishes.

// File: rtl/i2cm_seq_pkg.sv
package i2cm_seq_pkg;

   typedef enum logic [1:0] {
      CMD_START = 2'd0,
      CMD_WRITE = 2'd1,
      CMD_READ  = 2'd2,
      CMD_STOP  = 2'd3
   } eng_cmd_e;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_NEXT,
      ST_START,
      ST_XFER,
      ST_STOP,
      ST_DONE,
      ST_HALT
   } seq_state_e;

   typedef struct packed {
      logic recv;
      logic rpst;
      logic chain;
   } xfer_opts_t;

   localparam int OFF_CTRL  = 0;
   localparam int OFF_STAT  = 1;
   localparam int OFF_XSTAT = 2;
   localparam int OFF_MODE  = 3;
   localparam int OFF_MASK  = 4;
   localparam int OFF_XCNT  = 5;
   localparam int OFF_TADDR = 6;
   localparam int OFF_SRST  = 7;
   localparam int OFF_DATA  = 8;

endpackage

// File: rtl/i2cm_seq_fsm.sv
module i2cm_seq_fsm
   import i2cm_seq_pkg::*;
#(
   parameter int DATA_BYTES = 4,
   localparam int CNT_W = $clog2(DATA_BYTES)
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    go,
   input  logic                    halt_go,
   input  xfer_opts_t              cfg_opts,
   input  logic [CNT_W-1:0]        cfg_last,
   input  logic [6:0]              taddr7,
   input  logic [DATA_BYTES*8-1:0] wr_bytes,
   input  logic                    eng_done,
   input  logic                    eng_nack,
   input  logic [7:0]              eng_rdata,
   output logic                    busy,
   output logic                    bus_held,
   output logic                    eng_req,
   output eng_cmd_e                eng_cmd,
   output logic [7:0]              eng_wdata,
   output logic                    fin,
   output logic [CNT_W:0]          fin_cnt,
   output logic                    halt_fin,
   output logic                    err_set,
   output logic                    err_clr,
   output logic                    abort_set,
   output logic                    rd_we,
   output logic [CNT_W-1:0]        rd_idx,
   output logic [7:0]              rd_byte
);

   seq_state_e       state_q;
   logic [CNT_W:0]   idx_q;
   logic [CNT_W-1:0] last_q;
   xfer_opts_t       opts_q;
   logic             ok_done;
   logic             bad_done;

   assign ok_done  = eng_done && !eng_nack;
   assign bad_done = eng_done && eng_nack;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q  <= ST_IDLE;
         idx_q    <= '0;
         last_q   <= '0;
         opts_q   <= '0;
         bus_held <= 1'b0;
      end else begin
         case (state_q)
            ST_IDLE: begin
               if (halt_go) begin
                  state_q <= ST_HALT;
               end else if (go) begin
                  state_q <= ST_NEXT;
                  idx_q   <= '0;
                  last_q  <= cfg_last;
                  opts_q  <= cfg_opts;
               end
            end
            ST_NEXT: begin
               if (idx_q > {1'b0, last_q}) state_q <= ST_DONE;
               else if (!bus_held)         state_q <= ST_START;
               else                        state_q <= ST_XFER;
            end
            ST_START: begin
               if (bad_done) begin
                  bus_held <= 1'b0;
                  state_q  <= ST_DONE;
               end else if (ok_done) begin
                  bus_held <= 1'b1;
                  state_q  <= ST_XFER;
               end
            end
            ST_XFER: begin
               if (bad_done) begin
                  state_q <= ST_DONE;
               end else if (ok_done) begin
                  idx_q <= idx_q + 1'b1;
                  if (opts_q.rpst || !opts_q.chain) state_q <= ST_STOP;
                  else                              state_q <= ST_NEXT;
               end
            end
            ST_STOP: begin
               if (eng_done) begin
                  bus_held <= 1'b0;
                  state_q  <= ST_NEXT;
               end
            end
            ST_HALT: begin
               if (eng_done) begin
                  bus_held <= 1'b0;
                  state_q  <= ST_IDLE;
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   always_comb begin
      eng_req   = (state_q == ST_START) || (state_q == ST_XFER) ||
                  (state_q == ST_STOP)  || (state_q == ST_HALT);
      eng_cmd   = CMD_STOP;
      eng_wdata = 8'h00;
      if (state_q == ST_START) begin
         eng_cmd   = CMD_START;
         eng_wdata = {taddr7, opts_q.recv};
      end else if (state_q == ST_XFER) begin
         eng_cmd = opts_q.recv ? CMD_READ : CMD_WRITE;
         if (!opts_q.recv) eng_wdata = wr_bytes[idx_q[CNT_W-1:0]*8 +: 8];
      end
   end

   assign busy      = (state_q != ST_IDLE);
   assign fin       = (state_q == ST_DONE);
   assign fin_cnt   = idx_q;
   assign halt_fin  = (state_q == ST_HALT) && eng_done;
   assign err_set   = ((state_q == ST_START) || (state_q == ST_XFER)) && bad_done;
   assign abort_set = err_set;
   assign err_clr   = (state_q == ST_START) && ok_done;
   assign rd_we     = (state_q == ST_XFER) && ok_done && opts_q.recv;
   assign rd_idx    = idx_q[CNT_W-1:0];
   assign rd_byte   = eng_rdata;

   AST_NO_START_WHEN_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (eng_req && eng_cmd == CMD_START) |-> !bus_held); // R3
   AST_STOP_FREES_BUS: assert property (@(posedge clk) disable iff (!rst_n)
      (eng_req && eng_cmd == CMD_STOP && eng_done) |=> !bus_held); // R7
   AST_CMD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (eng_req && !eng_done) |=> (eng_req && $stable(eng_cmd) && $stable(eng_wdata))); // R12
   AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      fin |-> (fin_cnt <= (CNT_W+1)'(DATA_BYTES))); // R5

endmodule

// File: rtl/i2cm_seq_regs.sv
module i2cm_seq_regs
   import i2cm_seq_pkg::*;
#(
   parameter int         DATA_BYTES  = 4,
   parameter int         REG_AW      = 4,
   parameter logic [7:0] MODE_KEEP   = 8'h3D,
   parameter logic [7:0] STAT_W1C    = 8'h0A,
   parameter logic [7:0] XSTAT_W1C   = 8'h8F,
   parameter logic [7:0] XCNT_KEEP   = 8'h77,
   parameter logic [7:0] BUS_BUSY_CD = 8'h50,
   parameter logic [7:0] BUS_FREE_CD = 8'h40,
   localparam int CNT_W = $clog2(DATA_BYTES)
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    reg_wr,
   input  logic [REG_AW-1:0]       reg_addr,
   input  logic [7:0]              reg_wdata,
   output logic [7:0]              reg_rdata,
   output logic                    irq,
   input  logic                    busy,
   input  logic                    bus_held,
   input  logic                    fin,
   input  logic [CNT_W:0]          fin_cnt,
   input  logic                    halt_fin,
   input  logic                    err_set,
   input  logic                    err_clr,
   input  logic                    abort_set,
   input  logic                    rd_we,
   input  logic [CNT_W-1:0]        rd_idx,
   input  logic [7:0]              rd_byte,
   output logic                    go,
   output logic                    halt_go,
   output xfer_opts_t              cfg_opts,
   output logic [CNT_W-1:0]        cfg_last,
   output logic [6:0]              taddr7,
   output logic [DATA_BYTES*8-1:0] wr_bytes
);

   logic [7:0] ctrl_q, mode_q, mask_q, xcnt_q, taddr_q;
   logic       irqa_q, err_q, abort_q;
   logic       hit_ctrl, hit_stat, hit_xstat, hit_mode, hit_mask, hit_xcnt, hit_taddr;
   logic       ctrl_acc, srst, cmpl_evt, halt_evt, clr_irqa;

   assign hit_ctrl  = reg_wr && (reg_addr == REG_AW'(OFF_CTRL));
   assign hit_stat  = reg_wr && (reg_addr == REG_AW'(OFF_STAT));
   assign hit_xstat = reg_wr && (reg_addr == REG_AW'(OFF_XSTAT));
   assign hit_mode  = reg_wr && (reg_addr == REG_AW'(OFF_MODE));
   assign hit_mask  = reg_wr && (reg_addr == REG_AW'(OFF_MASK));
   assign hit_xcnt  = reg_wr && (reg_addr == REG_AW'(OFF_XCNT));
   assign hit_taddr = reg_wr && (reg_addr == REG_AW'(OFF_TADDR));
   assign srst      = reg_wr && (reg_addr == REG_AW'(OFF_SRST)) && reg_wdata[0] && !busy;

   assign ctrl_acc  = hit_ctrl && !busy;
   assign halt_go   = ctrl_acc && reg_wdata[7] && bus_held;
   assign go        = ctrl_acc && reg_wdata[0] && !(reg_wdata[7] && bus_held);
   assign cfg_opts  = '{recv: reg_wdata[1], rpst: reg_wdata[3], chain: reg_wdata[2]};
   assign cfg_last  = reg_wdata[4 +: CNT_W];
   assign taddr7    = taddr_q[7:1];

   assign cmpl_evt  = fin && (fin_cnt != '0) && mode_q[2] && mask_q[0];
   assign halt_evt  = halt_fin && mode_q[2] && mask_q[3];
   assign clr_irqa  = hit_stat && reg_wdata[1] && STAT_W1C[1];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         taddr_q <= 8'h00;
      end else if (hit_taddr) begin
         taddr_q <= reg_wdata;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n || srst) begin
         ctrl_q  <= 8'h00;
         mode_q  <= 8'h00;
         mask_q  <= 8'h00;
         xcnt_q  <= 8'h00;
         irqa_q  <= 1'b0;
         err_q   <= 1'b0;
         abort_q <= 1'b0;
         irq     <= 1'b0;
      end else begin
         if (ctrl_acc)  ctrl_q <= reg_wdata & 8'hFE;
         if (hit_mode)  mode_q <= reg_wdata & MODE_KEEP;
         if (hit_mask)  mask_q <= reg_wdata;
         if (fin)           xcnt_q <= 8'(fin_cnt);
         else if (hit_xcnt) xcnt_q <= reg_wdata & XCNT_KEEP;
         if (err_set)      err_q <= 1'b1;
         else if (err_clr) err_q <= 1'b0;
         else if (hit_stat && reg_wdata[2] && STAT_W1C[2]) err_q <= 1'b0;
         if (abort_set) abort_q <= 1'b1;
         else if (hit_xstat && reg_wdata[0] && XSTAT_W1C[0]) abort_q <= 1'b0;
         if (cmpl_evt || halt_evt) begin
            irqa_q <= 1'b1;
            irq    <= 1'b1;
         end else if (clr_irqa) begin
            irqa_q <= 1'b0;
            if (mode_q[2]) irq <= 1'b0;
         end
      end
   end

   for (genvar i = 0; i < DATA_BYTES; i++) begin : g_data
      logic [7:0] byte_q;
      always_ff @(posedge clk) begin
         if (!rst_n || srst) begin
            byte_q <= 8'h00;
         end else if (rd_we && rd_idx == CNT_W'(i)) begin
            byte_q <= rd_byte;
         end else if (reg_wr && !busy && reg_addr == REG_AW'(OFF_DATA + i)) begin
            byte_q <= reg_wdata;
         end
      end
      assign wr_bytes[i*8 +: 8] = byte_q;
   end

   always_comb begin
      reg_rdata = 8'h00;
      case (reg_addr)
         REG_AW'(OFF_CTRL):  reg_rdata = ctrl_q;
         REG_AW'(OFF_STAT):  reg_rdata = {5'b0, err_q, irqa_q, busy};
         REG_AW'(OFF_XSTAT): reg_rdata = (bus_held ? BUS_BUSY_CD : BUS_FREE_CD) | {7'b0, abort_q};
         REG_AW'(OFF_MODE):  reg_rdata = mode_q;
         REG_AW'(OFF_MASK):  reg_rdata = mask_q;
         REG_AW'(OFF_XCNT):  reg_rdata = xcnt_q;
         REG_AW'(OFF_TADDR): reg_rdata = taddr_q;
         default: begin
            for (int k = 0; k < DATA_BYTES; k++) begin
               if (reg_addr == REG_AW'(OFF_DATA + k)) reg_rdata = wr_bytes[k*8 +: 8];
            end
         end
      endcase
   end

   AST_IRQ_NEEDS_GIE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq) |-> $past(mode_q[2])); // R6
   AST_CTRL_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      (hit_ctrl && busy) |=> $stable(ctrl_q)); // R12
   AST_NACK_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
      abort_set |=> (err_q && abort_q)); // R4
   AST_ERR_NOT_SW: assert property (@(posedge clk) disable iff (!rst_n)
      (err_q && !err_clr && !srst) |=> err_q); // R8

endmodule

// File: rtl/i2cm_seq_top.sv
module i2cm_seq_top
   import i2cm_seq_pkg::*;
#(
   parameter int DATA_BYTES = 4,
   parameter int REG_AW     = 4,
   localparam int CNT_W = $clog2(DATA_BYTES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic [REG_AW-1:0] reg_addr,
   input  logic [7:0]        reg_wdata,
   output logic [7:0]        reg_rdata,
   output logic              busy,
   output logic              irq,
   output logic              eng_req,
   output logic [1:0]        eng_cmd,
   output logic [7:0]        eng_wdata,
   input  logic              eng_done,
   input  logic              eng_nack,
   input  logic [7:0]        eng_rdata
);

   initial begin
      if (DATA_BYTES < 2 || DATA_BYTES > 4 || (DATA_BYTES & (DATA_BYTES - 1)) != 0)
         $fatal(1, "DATA_BYTES must be 2 or 4 to fit the control count field");
      if (REG_AW < 4)
         $fatal(1, "REG_AW too narrow for the register map");
   end

   logic                    go, halt_go, bus_held, fin, halt_fin;
   logic                    err_set, err_clr, abort_set, rd_we;
   logic [CNT_W:0]          fin_cnt;
   logic [CNT_W-1:0]        rd_idx, cfg_last;
   logic [7:0]              rd_byte;
   logic [6:0]              taddr7;
   logic [DATA_BYTES*8-1:0] wr_bytes;
   xfer_opts_t              cfg_opts;
   eng_cmd_e                cmd_w;

   i2cm_seq_regs #(.DATA_BYTES(DATA_BYTES), .REG_AW(REG_AW)) u_regs (
      .clk, .rst_n, .reg_wr, .reg_addr, .reg_wdata, .reg_rdata, .irq,
      .busy, .bus_held, .fin, .fin_cnt, .halt_fin, .err_set, .err_clr,
      .abort_set, .rd_we, .rd_idx, .rd_byte, .go, .halt_go, .cfg_opts,
      .cfg_last, .taddr7, .wr_bytes
   );

   i2cm_seq_fsm #(.DATA_BYTES(DATA_BYTES)) u_fsm (
      .clk, .rst_n, .go, .halt_go, .cfg_opts, .cfg_last, .taddr7, .wr_bytes,
      .eng_done, .eng_nack, .eng_rdata, .busy, .bus_held, .eng_req,
      .eng_cmd(cmd_w), .eng_wdata, .fin, .fin_cnt, .halt_fin, .err_set,
      .err_clr, .abort_set, .rd_we, .rd_idx, .rd_byte
   );

   assign eng_cmd = cmd_w;

   AST_IDLE_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !eng_req); // R12

endmodule

// File: tb/i2cm_seq_top_bench.sv
module i2cm_seq_top_bench;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       reg_wr = 1'b0;
   logic [3:0] reg_addr = 4'h0;
   logic [7:0] reg_wdata = 8'h00;
   logic [7:0] reg_rdata;
   logic       busy, irq, eng_req;
   logic [1:0] eng_cmd;
   logic [7:0] eng_wdata;
   logic       eng_done = 1'b0;
   logic       eng_nack = 1'b0;
   logic [7:0] eng_rdata = 8'h00;

   int checks = 0;
   int errors = 0;

   i2cm_seq_top u_i2cm_seq_top (
      .clk, .rst_n, .reg_wr, .reg_addr, .reg_wdata, .reg_rdata, .busy, .irq,
      .eng_req, .eng_cmd, .eng_wdata, .eng_done, .eng_nack, .eng_rdata
   );

   always #10 clk = ~clk;

   // byte engine model
   int n_start = 0, n_write = 0, n_read = 0, n_stop = 0, n_op = 0, lat = 0;
   logic [7:0] start_byte = 8'h00;
   logic [7:0] wlog [64];
   int nack_at = -1, op_base = 0, rd_base = 0;

   always @(posedge clk) begin
      if (eng_done) begin
         eng_done <= 1'b0;
         eng_nack <= 1'b0;
      end else if (eng_req) begin
         if (lat == 2) begin
            lat      <= 0;
            eng_done <= 1'b1;
            eng_nack <= ((n_op - op_base) == nack_at);
            n_op     <= n_op + 1;
            case (eng_cmd)
               2'd0: begin n_start <= n_start + 1; start_byte <= eng_wdata; end
               2'd1: begin wlog[n_write % 64] <= eng_wdata; n_write <= n_write + 1; end
               2'd2: begin eng_rdata <= 8'hC0 + 8'(n_read - rd_base); n_read <= n_read + 1; end
               default: n_stop <= n_stop + 1;
            endcase
         end else begin
            lat <= lat + 1;
         end
      end
   end

   task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [3:0] a, input logic [7:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd(input logic [3:0] a, output logic [7:0] d);
      @(negedge clk);
      reg_addr = a;
      #1 d = reg_rdata;
   endtask

   task automatic rchk(input string req, input logic [3:0] a, input logic [7:0] exp);
      logic [7:0] v;
      rd(a, v);
      chk(req, v, exp);
   endtask

   task automatic wait_idle();
      int t = 0;
      while (busy && t < 3000) begin @(negedge clk); t++; end
      if (busy) chk("R12 idle timeout", 8'h01, 8'h00);
   endtask

   int s0, p0, w0, r0;
   task automatic mark(input int nk);
      @(negedge clk);
      s0 = n_start; p0 = n_stop; w0 = n_write; r0 = n_read;
      op_base = n_op; rd_base = n_read; nack_at = nk;
   endtask

   task automatic setup(input logic [7:0] mode, input logic [7:0] mask);
      wr(4'h7, 8'h01);
      wr(4'h6, 8'hA4);
      for (int i = 0; i < 4; i++) wr(4'(8 + i), 8'(8'h11 * (i + 1)));
      wr(4'h3, mode);
      wr(4'h4, mask);
   endtask

   typedef struct packed {
      logic [7:0] ctrl, mode, mask, nack, xcnt, stat, xstat;
      logic       irq;
      logic [3:0] starts, stops;
   } vec_t;

   localparam int NV = 5;
   localparam vec_t VECS [NV] = '{
      '{8'h01, 8'h04, 8'h01, 8'hFF, 8'd1, 8'h02, 8'h40, 1'b1, 4'd1, 4'd1},
      '{8'h31, 8'h00, 8'h01, 8'hFF, 8'd4, 8'h00, 8'h40, 1'b0, 4'd4, 4'd4},
      '{8'h2F, 8'h04, 8'h00, 8'hFF, 8'd3, 8'h00, 8'h40, 1'b0, 4'd3, 4'd3},
      '{8'h11, 8'h04, 8'h01, 8'h00, 8'd0, 8'h04, 8'h41, 1'b0, 4'd1, 4'd0},
      '{8'h1D, 8'h04, 8'h09, 8'hFF, 8'd2, 8'h02, 8'h40, 1'b1, 4'd2, 4'd2}
   };

   initial begin : watchdog
      #(20 * 150000);
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin : main
      logic [7:0] v;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      chk("R1 busy", {7'b0, busy}, 8'h00);
      chk("R1 irq", {7'b0, irq}, 8'h00);
      rchk("R1 ctrl", 4'h0, 8'h00);
      rchk("R1 stat", 4'h1, 8'h00);
      rchk("R1 xstat", 4'h2, 8'h40);
      rchk("R1 mode", 4'h3, 8'h00);
      rchk("R1 mask", 4'h4, 8'h00);
      rchk("R1 xcnt", 4'h5, 8'h00);
      rchk("R1 taddr", 4'h6, 8'h00);
      rchk("R1 data0", 4'h8, 8'h00);

      // vector table: R2 R3 R4 R5 R6
      for (int n = 0; n < NV; n++) begin
         setup(VECS[n].mode, VECS[n].mask);
         mark(VECS[n].nack == 8'hFF ? -1 : int'(VECS[n].nack));
         wr(4'h0, VECS[n].ctrl);
         wait_idle();
         rchk("R5 xcnt", 4'h5, VECS[n].xcnt);
         rchk("R6 R4 stat", 4'h1, VECS[n].stat);
         rchk("R9 R4 xstat", 4'h2, VECS[n].xstat);
         chk("R6 irq", {7'b0, irq}, {7'b0, VECS[n].irq});
         chk("R3 starts", 8'(n_start - s0), {4'b0, VECS[n].starts});
         chk("R3 stops", 8'(n_stop - p0), {4'b0, VECS[n].stops});
         rchk("R2 ctrl readback", 4'h0, VECS[n].ctrl & 8'hFE);
         chk("R2 start byte", start_byte, 8'hA4 | {7'b0, VECS[n].ctrl[1]});
         for (int i = 0; i < int'(VECS[n].xcnt); i++) begin
            if (VECS[n].ctrl[1]) rchk("R2 read data", 4'(8 + i), 8'(8'hC0 + i));
            else chk("R2 write data", wlog[(w0 + i) % 64], 8'(8'h11 * (i + 1)));
         end
      end

      // R3 R7: chained transfer keeps bus, next one skips start, halt frees it
      setup(8'h04, 8'h08);
      mark(-1);
      wr(4'h0, 8'h15);
      wait_idle();
      chk("R3 chain starts", 8'(n_start - s0), 8'd1);
      chk("R3 chain stops", 8'(n_stop - p0), 8'd0);
      chk("R3 chain writes", 8'(n_write - w0), 8'd2);
      rchk("R9 held xstat", 4'h2, 8'h50);
      rchk("R6 no cmpl irq masked", 4'h1, 8'h00);
      mark(-1);
      wr(4'h0, 8'h05);
      wait_idle();
      chk("R3 no restart", 8'(n_start - s0), 8'd0);
      chk("R3 held write data", wlog[w0 % 64], 8'h11);
      rchk("R5 xcnt 1", 4'h5, 8'h01);
      mark(-1);
      wr(4'h0, 8'h80);
      wait_idle();
      chk("R7 halt stop", 8'(n_stop - p0), 8'd1);
      rchk("R7 halt frees bus", 4'h2, 8'h40);
      rchk("R7 halt stat", 4'h1, 8'h02);
      chk("R7 halt irq", {7'b0, irq}, 8'h01);
      wr(4'h1, 8'h02);
      chk("R8 irq dropped", {7'b0, irq}, 8'h00);
      rchk("R8 irqa cleared", 4'h1, 8'h00);

      // R4 R8 R9: data NACK keeps bus held
      setup(8'h04, 8'h01);
      mark(4);
      wr(4'h0, 8'h21);
      wait_idle();
      rchk("R4 data nack xcnt", 4'h5, 8'h01);
      rchk("R4 data nack stat", 4'h1, 8'h06);
      rchk("R4 data nack xstat", 4'h2, 8'h51);
      chk("R6 irq after 1 byte", {7'b0, irq}, 8'h01);
      wr(4'h1, 8'hFF);
      rchk("R8 err kept", 4'h1, 8'h04);
      chk("R8 irq low", {7'b0, irq}, 8'h00);
      wr(4'h2, 8'hFF);
      rchk("R9 abort cleared", 4'h2, 8'h50);
      wr(4'h4, 8'h00);
      mark(-1);
      wr(4'h0, 8'h80);
      wait_idle();
      rchk("R7 halt after nack", 4'h2, 8'h40);
      chk("R7 halt masked irq", {7'b0, irq}, 8'h00);
      mark(-1);
      wr(4'h0, 8'h01);
      wait_idle();
      rchk("R4 err cleared by ack", 4'h1, 8'h00);

      // R10 R5 masks
      wr(4'h3, 8'hFF);
      rchk("R10 mode keep", 4'h3, 8'h3D);
      wr(4'h5, 8'hFF);
      rchk("R5 xcnt keep", 4'h5, 8'h77);

      // R11 soft reset
      wr(4'h4, 8'h5A);
      wr(4'h7, 8'h01);
      rchk("R11 mode", 4'h3, 8'h00);
      rchk("R11 mask", 4'h4, 8'h00);
      rchk("R11 xcnt", 4'h5, 8'h00);
      rchk("R11 data0", 4'h8, 8'h00);
      rchk("R11 taddr kept", 4'h6, 8'hA4);

      // R12 busy and ignored writes
      setup(8'h00, 8'h00);
      mark(-1);
      wr(4'h0, 8'h31);
      chk("R12 busy", {7'b0, busy}, 8'h01);
      rchk("R12 stat busy", 4'h1, 8'h01);
      wr(4'h0, 8'h01);
      wr(4'h8, 8'hEE);
      wait_idle();
      chk("R12 one transfer", 8'(n_start - s0), 8'd4);
      rchk("R12 ctrl unchanged", 4'h0, 8'h30);
      rchk("R12 data unchanged", 4'h8, 8'h11);
      rd(4'h1, v);
      chk("R12 stat idle", v, 8'h00);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule